// File: doc/BRIEF.md
# Queue Interrupt Source Selector

This block turns per-queue status flags into interrupt requests for 64 hardware queues, split into a lower half (queues 0 to 31) and an upper half (queues 32 to 63). Each lower queue brings four status flags, and software chooses which one of them (optionally inverted) is that queue's interrupt condition. Each upper queue has one fixed condition: its nearly-empty flag is low. Upper queues therefore bring only their nearly-empty flag.

For each half, software sees a 32-bit enable register and a 32-bit pending register. A pending bit is set on a rising edge of an enabled queue's condition and is cleared by writing 1 to it. Clearing an enable bit also drops that queue's pending bit. Each half drives its own interrupt line. Software reads the pending word and services queues from the highest bit downward.

Register access is a single-cycle write strobe plus a combinational read port, addressed by a 3-bit index.

Top module: `qirq_selector`

## Requirements
- R1: After reset every register (addresses 0 to 7) reads 0 and both interrupt outputs are low.
- R2: Addresses 0 to 3 hold the source fields. Queue q's 3-bit field sits in bits [4*(q%8)+2 : 4*(q%8)] of address q/8. Bit 4*(q%8)+3 is reserved: it is not stored and it reads 0.
- R3: Field bits [1:0] pick flag index f of a lower queue, where flag f of queue q arrives on lo_flags_i[4*q+f].
- R4: When field bit 2 is 1, the condition is the inverse of the selected flag.
- R5: The condition of upper queue q+32 is the inverse of hi_near_empty_i[q]. The source fields do not affect upper queues.
- R6: A pending bit is set only in the cycle after a 0-to-1 change of its queue's condition while the queue was enabled. A condition that stays high does not set the bit again, and neither does enabling a queue whose condition is already high.
- R7: A write to address 6 (lower half) or 7 (upper half) clears every pending bit written as 1 and leaves bits written as 0 unchanged.
- R8: Addresses 4 (lower) and 5 (upper) are the enable registers. Writing 0 to an enable bit clears that queue's pending bit in the same cycle.
- R9: irq_o[0] is high while any lower pending bit is set, and irq_o[1] is high while any upper pending bit is set. Both follow the pending bits with no added delay.
- R10: If a rising edge and a clearing write hit the same pending bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 32 | Read data (combinational) |
| lo_flags_i | input | 128 | Four status flags per lower queue |
| hi_near_empty_i | input | 32 | Nearly-empty flag per upper queue |
| irq_o | output | 2 | Interrupt request per half |

## Verification
The source-select path is driven with a plain selector, with an inverted selector, and by toggling a flag that is not selected. These patterns separate a wrong flag index from a missing inversion. The edge detector is driven by a condition that is held high, one that is already high when the queue is enabled, and one that is toggled low and then high. These tell edge triggering apart from level triggering. Clearing writes are tried with all-zero data, with a matching bit, and in the same cycle as a fresh edge, and disabling is tried on a pending queue. A behavioural model compares the read port and both interrupt lines on every clock, and isolates faults in decode, priority and per-half routing.

// File: rtl/qirq_pkg.sv
`timescale 1ns/1ps
package qirq_pkg;
    localparam int FLAGS_PER_Q = 4;
    localparam int SLOT_W      = 4;
    localparam int FIELD_W     = 3;
    localparam int SRC_REGS    = 4;
    localparam int ADDR_W      = 3;

    localparam logic [ADDR_W-1:0] ADR_EN_LO = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_EN_HI = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_ST_LO = 3'd6;
    localparam logic [ADDR_W-1:0] ADR_ST_HI = 3'd7;

    typedef struct packed {
        logic       inv;
        logic [1:0] sel;
    } src_field_t;
endpackage

// File: rtl/qirq_cond_sel.sv
`timescale 1ns/1ps
module qirq_cond_sel
    import qirq_pkg::*;
#(
    parameter int NQ = 32
) (
    input  logic [NQ*FLAGS_PER_Q-1:0] flags_i,
    input  src_field_t [NQ-1:0]       src_i,
    output logic [NQ-1:0]             cond_o
);
    for (genvar q = 0; q < NQ; q++) begin : g_q
        logic [FLAGS_PER_Q-1:0] fl;
        assign fl        = flags_i[q*FLAGS_PER_Q +: FLAGS_PER_Q];
        assign cond_o[q] = fl[src_i[q].sel] ^ src_i[q].inv;
    end
endmodule

// File: rtl/qirq_bank.sv
`timescale 1ns/1ps
module qirq_bank #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         en_wr_i,
    input  logic         clr_wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] cond_i,
    output logic [W-1:0] en_o,
    output logic [W-1:0] pend_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] en;
        logic [W-1:0] pend;
        logic [W-1:0] prev;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        logic [W-1:0] rise;
        logic [W-1:0] clr;
        bank_d      = bank_q;
        rise        = cond_i & ~bank_q.prev;
        clr         = clr_wr_i ? wdata_i : '0;
        bank_d.en   = en_wr_i ? wdata_i : bank_q.en;
        bank_d.pend = ((bank_q.pend & ~clr) | (rise & bank_q.en)) & bank_d.en;
        bank_d.prev = cond_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) bank_q <= '0;
        else         bank_q <= bank_d;
    end

    assign en_o   = bank_q.en;
    assign pend_o = bank_q.pend;
    assign irq_o  = |bank_q.pend;

    // R8
    pend_in_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bank_q.pend & ~bank_q.en) == '0);
    // R6
    set_needs_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((bank_q.pend & ~$past(bank_q.pend)) & ~$past(cond_i & bank_q.en)) == '0);
    // R7
    clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_wr_i |=> (bank_q.pend & $past(wdata_i) & ~$past(cond_i)) == '0);
    // R9
    irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(|(cond_i & bank_q.en)));
endmodule

// File: rtl/qirq_selector.sv
`timescale 1ns/1ps
module qirq_selector
    import qirq_pkg::*;
#(
    parameter int HALF_Q = 32
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        wr_en_i,
    input  logic [2:0]                  wr_addr_i,
    input  logic [HALF_Q-1:0]           wr_data_i,
    input  logic [2:0]                  rd_addr_i,
    output logic [HALF_Q-1:0]           rd_data_o,
    input  logic [HALF_Q*4-1:0]         lo_flags_i,
    input  logic [HALF_Q-1:0]           hi_near_empty_i,
    output logic [1:0]                  irq_o
);
    localparam int QPR   = HALF_Q / SLOT_W;
    localparam int SEL_W = $clog2(SRC_REGS);
    localparam logic [HALF_Q-1:0] RSV_MASK = {QPR{4'b1000}};

    typedef struct packed {
        src_field_t [HALF_Q-1:0] src;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    src_field_t [HALF_Q-1:0] src_next;
    logic [SRC_REGS-1:0][HALF_Q-1:0] src_words;
    logic [1:0][HALF_Q-1:0] cond, en, pend;

    for (genvar q = 0; q < HALF_Q; q++) begin : g_src
        localparam logic [ADDR_W-1:0] REG_IDX = ADDR_W'(q / QPR);
        assign src_next[q] = (wr_en_i && wr_addr_i == REG_IDX)
                           ? src_field_t'(wr_data_i[(q % QPR)*SLOT_W +: FIELD_W])
                           : cfg_q.src[q];
        assign src_words[q / QPR][(q % QPR)*SLOT_W +: SLOT_W] = {1'b0, cfg_q.src[q]};
    end

    always_comb begin
        cfg_d     = cfg_q;
        cfg_d.src = src_next;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    qirq_cond_sel #(.NQ(HALF_Q)) i_cond_lo (
        .flags_i (lo_flags_i),
        .src_i   (cfg_q.src),
        .cond_o  (cond[0])
    );
    assign cond[1] = ~hi_near_empty_i;

    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam logic [ADDR_W-1:0] EN_ADR = ADR_EN_LO + ADDR_W'(h);
        localparam logic [ADDR_W-1:0] ST_ADR = ADR_ST_LO + ADDR_W'(h);
        qirq_bank #(.W(HALF_Q)) i_bank (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .en_wr_i  (wr_en_i && wr_addr_i == EN_ADR),
            .clr_wr_i (wr_en_i && wr_addr_i == ST_ADR),
            .wdata_i  (wr_data_i),
            .cond_i   (cond[h]),
            .en_o     (en[h]),
            .pend_o   (pend[h]),
            .irq_o    (irq_o[h])
        );
    end

    always_comb begin
        case (rd_addr_i)
            ADR_EN_LO: rd_data_o = en[0];
            ADR_EN_HI: rd_data_o = en[1];
            ADR_ST_LO: rd_data_o = pend[0];
            ADR_ST_HI: rd_data_o = pend[1];
            default:   rd_data_o = src_words[rd_addr_i[SEL_W-1:0]];
        endcase
    end

    // R2
    rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_addr_i < ADR_EN_LO) |-> (rd_data_o & RSV_MASK) == '0);
endmodule

// File: tb/test_qirq_selector.sv
`timescale 1ns/1ps
module test_qirq_selector;
    localparam int HQ = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [HQ-1:0] wr_data = '0;
    logic [2:0]    rd_addr = '0;
    logic [HQ-1:0] rd_data;
    logic [HQ*4-1:0] lo_flags = '0;
    logic [HQ-1:0] hi_ne = '0;
    logic [1:0]    irq;

    qirq_selector #(.HALF_Q(HQ)) i_qirq_selector (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .lo_flags_i(lo_flags), .hi_near_empty_i(hi_ne), .irq_o(irq)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;

    // behavioural model
    logic [2:0]    m_src [HQ];
    logic [HQ-1:0] m_en_lo = '0, m_en_hi = '0, m_st_lo = '0, m_st_hi = '0;
    logic [HQ-1:0] m_pv_lo = '0, m_pv_hi = '0;

    initial for (int i = 0; i < HQ; i++) m_src[i] = '0;

    function automatic logic [HQ-1:0] m_read(input logic [2:0] a);
        logic [HQ-1:0] v = '0;
        case (a)
            3'd4: v = m_en_lo;
            3'd5: v = m_en_hi;
            3'd6: v = m_st_lo;
            3'd7: v = m_st_hi;
            default: for (int k = 0; k < 8; k++) v[k*4 +: 4] = {1'b0, m_src[int'(a)*8 + k]};
        endcase
        return v;
    endfunction

    task automatic model_update();
        logic [HQ-1:0] cl, ch, en_lo_n, en_hi_n, clr_lo, clr_hi;
        for (int q = 0; q < HQ; q++)
            cl[q] = lo_flags[4*q + int'(m_src[q][1:0])] ^ m_src[q][2];
        ch = ~hi_ne;
        en_lo_n = (wr_en && wr_addr == 3'd4) ? wr_data : m_en_lo;
        en_hi_n = (wr_en && wr_addr == 3'd5) ? wr_data : m_en_hi;
        clr_lo  = (wr_en && wr_addr == 3'd6) ? wr_data : '0;
        clr_hi  = (wr_en && wr_addr == 3'd7) ? wr_data : '0;
        m_st_lo = ((m_st_lo & ~clr_lo) | (cl & ~m_pv_lo & m_en_lo)) & en_lo_n;
        m_st_hi = ((m_st_hi & ~clr_hi) | (ch & ~m_pv_hi & m_en_hi)) & en_hi_n;
        m_en_lo = en_lo_n;
        m_en_hi = en_hi_n;
        m_pv_lo = cl;
        m_pv_hi = ch;
        if (wr_en && wr_addr < 3'd4)
            for (int k = 0; k < 8; k++) m_src[int'(wr_addr)*8 + k] = wr_data[k*4 +: 3];
    endtask

    task automatic chk(input string tag, input logic [HQ-1:0] act, input logic [HQ-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        cyc++;
        @(negedge clk);
        rd_addr = 3'(cyc % 8);
        #0.5;
        chk(rd_addr < 3'd4 ? "R2 model src" : (rd_addr < 3'd6 ? "R8 model en" : "R6 model pend"),
            rd_data, m_read(rd_addr));
        chk("R9 model irq", HQ'(irq), HQ'({|m_st_hi, |m_st_lo}));
    endtask

    task automatic rd(input logic [2:0] a, output logic [HQ-1:0] v);
        rd_addr = a;
        #0.5;
        v = rd_data;
    endtask

    task automatic wr(input logic [2:0] a, input logic [HQ-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    logic [HQ-1:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 reset reg", v, '0);
        end
        chk("R1 reset irq", HQ'(irq), '0);
        tick();

        // R2 field layout and reserved bits
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); chk("R2 reserved read 0", v, 32'h7777_7777);
        wr(3'd1, 32'h1234_5670);
        rd(3'd1, v); chk("R2 pattern", v, 32'h1234_5670);
        wr(3'd0, '0);
        wr(3'd1, '0);

        // R3 flag selection: queue 5 selects flag 2
        wr(3'd0, 32'h0020_0000);
        wr(3'd4, 32'h20);
        lo_flags[20] = 1'b1; tick(); tick();
        rd(3'd6, v); chk("R3 unselected flag ignored", v, '0);
        lo_flags[22] = 1'b1; tick();
        rd(3'd6, v); chk("R3 selected flag sets", v, 32'h20);
        chk("R9 irq lower", HQ'(irq), 32'h1);

        // R7 clear on write 1
        wr(3'd6, '0);
        rd(3'd6, v); chk("R7 zero write keeps", v, 32'h20);
        wr(3'd6, 32'h20);
        rd(3'd6, v); chk("R7 one write clears", v, '0);
        chk("R7 irq drops", HQ'(irq), '0);

        // R6 held condition does not re-set
        tick(); tick(); tick();
        rd(3'd6, v); chk("R6 level no retrigger", v, '0);
        lo_flags[22] = 1'b0; tick();
        lo_flags[22] = 1'b1; tick();
        rd(3'd6, v); chk("R6 new edge sets", v, 32'h20);
        wr(3'd6, 32'h20);

        // R4 inversion: queue 9 selects flag 1 inverted
        wr(3'd1, 32'h50);
        wr(3'd4, 32'h200);
        tick(); tick();
        rd(3'd6, v); chk("R6 enable while high no set", v, '0);
        lo_flags[37] = 1'b1; tick();
        rd(3'd6, v); chk("R4 flag high gives no event", v, '0);
        lo_flags[37] = 1'b0; tick();
        rd(3'd6, v); chk("R4 inverted edge sets", v, 32'h200);

        // R8 disabling clears pending
        wr(3'd4, '0);
        rd(3'd6, v); chk("R8 disable clears", v, '0);
        chk("R8 irq low", HQ'(irq), '0);

        // R5 upper half fixed source, queue 35
        wr(3'd5, 32'h8);
        wr(3'd0, 32'h7777_7777);
        hi_ne[3] = 1'b1; tick(); tick();
        rd(3'd7, v); chk("R5 nearly-empty high no event", v, '0);
        hi_ne[3] = 1'b0; tick();
        rd(3'd7, v); chk("R5 not-nearly-empty edge sets", v, 32'h8);
        chk("R9 irq upper only", HQ'(irq), 32'h2);

        // R9 both lines: queue 0 selects flag 3 inverted
        wr(3'd4, 32'h1);
        lo_flags[3] = 1'b1; tick();
        lo_flags[3] = 1'b0; tick();
        chk("R9 both irq", HQ'(irq), 32'h3);
        wr(3'd6, 32'h1);
        chk("R9 lower cleared upper kept", HQ'(irq), 32'h2);

        // R10 set beats clear
        wr(3'd7, 32'h8);
        rd(3'd7, v); chk("R7 upper clear", v, '0);
        hi_ne[3] = 1'b1; tick();
        hi_ne[3] = 1'b0;
        wr(3'd7, 32'h8);
        rd(3'd7, v); chk("R10 edge wins over clear", v, 32'h8);
        wr(3'd7, 32'h8);
        rd(3'd7, v); chk("R7 final clear", v, '0);
        tick(); tick();

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule